// File: doc/BRIEF.md
# Two-Key Register Write-Protection Gate

This block sits between a register write bus and a peripheral's register file and decides, write by write, whether the register file may accept the write. Writes that target the protected part of the address map are let through only while the gate is open. That part of the map holds the clock, alarm, control, status-clear, interrupt-enable, oscillator and power-control registers. While the gate is closed, such writes are dropped and flagged with a one-cycle violation pulse. Writes above the protected window always pass.

The gate opens only after an ordered pair of 32-bit key words has been written. The first key goes to key register A at byte offset 0x6C and the second to key register B at offset 0x70. Any other value written to either key register closes the gate again, and writing zero is the usual way to do that. Key writes are consumed by the gate and never reach the register file.

Every output is registered. The forwarded write, the violation pulse and the open state for a write sampled at clock edge k all appear just after edge k. The gate has no read path, so reads of the register file are never held back.

Top module: `kick_gate`

## Requirements
- R1: While `rst` is high, and after it falls, the gate is closed: `unlocked`, `fwd_we` and `wr_violation` are 0 until a write changes them.
- R2: A write to any address above PROT_HI (default 0x98) that is not a key address is forwarded one cycle later on `fwd_we`/`fwd_addr`/`fwd_data`, whether the gate is open or closed.
- R3: A write to a protected address (0x00 up to PROT_HI, key addresses excluded) while the gate is closed is not forwarded (`fwd_we` stays 0) and raises `wr_violation` for exactly the next cycle.
- R4: Writing 0x83E70B13 to address 0x6C and then 0x95A4F1E0 to address 0x70 opens the gate (`unlocked` = 1 the cycle after the second write). While the gate is open, protected writes are forwarded with their address and data and raise no violation.
- R5: A correct second key with no correct first key pending leaves the gate closed.
- R6: Any value other than the expected key, zero included, written to either key address closes the gate and discards a pending first key. This holds from the half-armed state and from the open state.
- R7: The keys in reverse order (second key first) do not open the gate.
- R8: Writes to either key address are never forwarded and never raise a violation.
- R9: `fwd_we` and `wr_violation` are single-cycle pulses per write. They are 0 in a cycle that follows an idle bus cycle, and they are never high together.
- R10: Writes to non-key addresses between the first and second key do not break the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W (8) | Byte address of the write |
| wr_data | input | DATA_W (32) | Write data |
| fwd_we | output | 1 | Registered write enable toward the register file |
| fwd_addr | output | ADDR_W (8) | Address of the forwarded write |
| fwd_data | output | DATA_W (32) | Data of the forwarded write |
| wr_violation | output | 1 | One-cycle pulse for a write dropped by protection |
| unlocked | output | 1 | Gate open state |

## Verification
The hardest state to reach is the half-armed one, where a correct first key is pending. It is only observable from its effect on the next write to key register B. The stimulus drives it deliberately with several orders: a lone second key, reversed keys, a wrong or zero second key, a repeated wrong first key, and unrelated writes between the two keys. Each ordering is followed by a protected write, so that the hidden state shows up at the ports. Every address in the 8-bit map is then swept with the gate closed and again with it open, and the bench compares each result with its own model of the key sequence.

// File: rtl/kick_gate_pkg.sv
package kick_gate_pkg;
  typedef enum logic [1:0] {
    GATE_LOCKED = 2'd0,
    GATE_HALF   = 2'd1,
    GATE_OPEN   = 2'd2
  } gate_state_e;
endpackage

// File: rtl/kick_addr_decode.sv
module kick_addr_decode #(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] KEY_A_ADDR = 8'h6C,
  parameter logic [ADDR_W-1:0] KEY_B_ADDR = 8'h70,
  parameter logic [ADDR_W-1:0] PROT_HI    = 8'h98
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_key_a,
  output logic              hit_key_b,
  output logic              hit_prot
);
  always_comb begin
    hit_key_a = (addr == KEY_A_ADDR);
    hit_key_b = (addr == KEY_B_ADDR);
    hit_prot  = (addr <= PROT_HI) && !hit_key_a && !hit_key_b;
  end
endmodule

// File: rtl/kick_seq_fsm.sv
module kick_seq_fsm
  import kick_gate_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] KEY_A_VAL = 32'h83E7_0B13,
  parameter logic [DATA_W-1:0] KEY_B_VAL = 32'h95A4_F1E0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              hit_key_a,
  input  logic              hit_key_b,
  input  logic [DATA_W-1:0] data,
  output logic              is_open
);
  gate_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (wr_en && hit_key_a) begin
      state_d = (data == KEY_A_VAL) ? GATE_HALF : GATE_LOCKED;
    end else if (wr_en && hit_key_b) begin
      state_d = (state_q == GATE_HALF && data == KEY_B_VAL) ? GATE_OPEN : GATE_LOCKED;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= GATE_LOCKED;
    else     state_q <= state_d;
  end

  assign is_open = (state_q == GATE_OPEN);

  // R4 R5 R7
  open_from_half_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(is_open) |-> $past(state_q) == GATE_HALF);

  // R10
  other_write_keeps_state_chk: assert property (@(posedge clk) disable iff (rst)
    (!hit_key_a && !hit_key_b) |=> $stable(state_q));
endmodule

// File: rtl/kick_fwd_stage.sv
module kick_fwd_stage #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              hit_key,
  input  logic              hit_prot,
  input  logic              is_open,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              fwd_we,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_data,
  output logic              violation
);
  logic pass_ok;
  logic drop;

  always_comb begin
    pass_ok = wr_en && !hit_key && (!hit_prot || is_open);
    drop    = wr_en && hit_prot && !is_open;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_we    <= 1'b0;
      fwd_addr  <= '0;
      fwd_data  <= '0;
      violation <= 1'b0;
    end else begin
      fwd_we    <= pass_ok;
      violation <= drop;
      if (pass_ok) begin
        fwd_addr <= addr;
        fwd_data <= data;
      end
    end
  end

  // R9
  pulse_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fwd_we, violation}));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (!fwd_we && !violation));
endmodule

// File: rtl/kick_gate.sv
module kick_gate #(
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 32,
  parameter logic [ADDR_W-1:0] KEY_A_ADDR = 8'h6C,
  parameter logic [ADDR_W-1:0] KEY_B_ADDR = 8'h70,
  parameter logic [ADDR_W-1:0] PROT_HI    = 8'h98,
  parameter logic [DATA_W-1:0] KEY_A_VAL  = 32'h83E7_0B13,
  parameter logic [DATA_W-1:0] KEY_B_VAL  = 32'h95A4_F1E0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              fwd_we,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_data,
  output logic              wr_violation,
  output logic              unlocked
);
  logic hit_key_a, hit_key_b, hit_prot;
  logic is_open;

  kick_addr_decode #(
    .ADDR_W(ADDR_W), .KEY_A_ADDR(KEY_A_ADDR), .KEY_B_ADDR(KEY_B_ADDR), .PROT_HI(PROT_HI)
  ) u_decode (
    .addr(wr_addr), .hit_key_a(hit_key_a), .hit_key_b(hit_key_b), .hit_prot(hit_prot)
  );

  kick_seq_fsm #(
    .DATA_W(DATA_W), .KEY_A_VAL(KEY_A_VAL), .KEY_B_VAL(KEY_B_VAL)
  ) u_fsm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .hit_key_a(hit_key_a), .hit_key_b(hit_key_b),
    .data(wr_data), .is_open(is_open)
  );

  kick_fwd_stage #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_fwd (
    .clk(clk), .rst(rst), .wr_en(wr_en), .hit_key(hit_key_a || hit_key_b),
    .hit_prot(hit_prot), .is_open(is_open), .addr(wr_addr), .data(wr_data),
    .fwd_we(fwd_we), .fwd_addr(fwd_addr), .fwd_data(fwd_data), .violation(wr_violation)
  );

  assign unlocked = is_open;

  // R6
  wrong_key_b_relock_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit_key_b && wr_data != KEY_B_VAL) |=> !unlocked);

  // R6
  wrong_key_a_relock_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit_key_a) |=> !unlocked);

  // R8
  key_not_forwarded_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (hit_key_a || hit_key_b)) |=> (!fwd_we && !wr_violation));

  // R2
  high_addr_passes_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr > PROT_HI && !hit_key_a && !hit_key_b) |=> fwd_we);

  // R3
  closed_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit_prot && !unlocked) |=> (wr_violation && !fwd_we));
endmodule

// File: tb/kick_gate_tb.sv
module kick_gate_tb;
  localparam logic [7:0]  KA  = 8'h6C;
  localparam logic [7:0]  KB  = 8'h70;
  localparam logic [7:0]  PHI = 8'h98;
  localparam logic [31:0] VA  = 32'h83E7_0B13;
  localparam logic [31:0] VB  = 32'h95A4_F1E0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        fwd_we, wr_violation, unlocked;
  logic [7:0]  fwd_addr;
  logic [31:0] fwd_data;

  int checks = 0;
  int fails  = 0;
  int mst    = 0; // model: 0 closed, 1 half, 2 open

  always #2 clk = ~clk;

  kick_gate u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fwd_we(fwd_we), .fwd_addr(fwd_addr), .fwd_data(fwd_data),
    .wr_violation(wr_violation), .unlocked(unlocked)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
    bit is_key, prot, exp_we, exp_v;
    is_key = (a == KA) || (a == KB);
    prot   = (a <= PHI) && !is_key;
    exp_we = !is_key && (!prot || mst == 2);
    exp_v  = prot && mst != 2;
    if (a == KA)      mst = (d == VA) ? 1 : 0;
    else if (a == KB) mst = (mst == 1 && d == VB) ? 2 : 0;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    chk(fwd_we == exp_we, req, "fwd_we", 64'(fwd_we), 64'(exp_we));
    chk(wr_violation == exp_v, req, "wr_violation", 64'(wr_violation), 64'(exp_v));
    chk(unlocked == (mst == 2), req, "unlocked", 64'(unlocked), 64'(mst == 2));
    if (exp_we) begin
      chk(fwd_addr == a, req, "fwd_addr", 64'(fwd_addr), 64'(a));
      chk(fwd_data == d, req, "fwd_data", 64'(fwd_data), 64'(d));
    end
    @(negedge clk);
    // R9: one-cycle pulses only
    chk(!fwd_we && !wr_violation, "R9", "pulse after idle",
        64'({fwd_we, wr_violation}), 64'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state while reset held
    chk(!unlocked && !fwd_we && !wr_violation, "R1", "during reset",
        64'({unlocked, fwd_we, wr_violation}), 64'(0));
    rst = 1'b0;
    @(negedge clk);
    chk(!unlocked && !fwd_we && !wr_violation, "R1", "after reset",
        64'({unlocked, fwd_we, wr_violation}), 64'(0));

    // R2 R3: sweep every non-key address while closed
    for (int a = 0; a < 256; a++)
      if (a[7:0] != KA && a[7:0] != KB) wr(a[7:0], 32'(a * 7 + 3), "R2/R3");

    // R5: second key alone
    wr(KB, VB, "R5");
    wr(8'h00, 32'h11, "R5");
    // R7: reversed order
    wr(KB, VB, "R7");
    wr(KA, VA, "R7");
    wr(8'h04, 32'h22, "R7");
    // R6: zero second key after a good first key
    wr(KB, 32'h0, "R6");
    wr(KB, VB, "R6");
    wr(8'h08, 32'h33, "R6");
    // R6: wrong first key discards pending one
    wr(KA, VA, "R6");
    wr(KA, VA ^ 32'h1, "R6");
    wr(KB, VB, "R6");
    wr(8'h0C, 32'h44, "R6");
    // R8: wrong second key value
    wr(KA, VA, "R8");
    wr(KB, VB ^ 32'h8000_0000, "R8");

    // R10: unrelated writes inside the sequence
    wr(KA, VA, "R10");
    wr(8'hA0, 32'h55, "R10");
    wr(8'h10, 32'h66, "R10");
    wr(KB, VB, "R10");

    // R4: sweep every non-key address while open
    for (int a = 0; a < 256; a++)
      if (a[7:0] != KA && a[7:0] != KB) wr(a[7:0], ~32'(a * 5), "R4/R2");

    // R6: zero to key A relocks from open
    wr(KA, 32'h0, "R6");
    wr(8'h14, 32'h77, "R6");
    // R6: zero to key B relocks from open
    wr(KA, VA, "R4");
    wr(KB, VB, "R4");
    wr(8'h18, 32'h88, "R4");
    wr(KB, 32'h0, "R6");
    wr(8'h18, 32'h99, "R6");

    // R1: reset while open closes the gate
    wr(KA, VA, "R4");
    wr(KB, VB, "R4");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mst = 0;
    @(negedge clk);
    chk(!unlocked, "R1", "reset from open", 64'(unlocked), 64'(0));
    wr(8'h1C, 32'hAA, "R1");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule